// File: doc/BRIEF.md
# Predicted Value Holding Table

This block keeps the values that a load value predictor has produced for physical registers whose real result is not yet known. Each held value is tagged with its destination physical register number and with the age of the instruction that made it. In any cycle up to two new predictions can arrive. A prediction that finds no free slot is dropped, and the requester is told so on an accept flag one cycle later.

Beside the table sits one "predicted" mark for each architectural register. Two read ports each carry an architectural register, the physical register it maps to, and the value the register file returned for it. When the mark is set and the table holds that physical register, the read returns the held value. Otherwise it returns the register-file value. A set mark with no matching entry raises an error flag, and the read uses the register-file value.

When a predicted load executes, its entry is freed. Its mark is cleared only if the rename map still points the architectural register at that physical register. A flush frees every entry younger than the flush age and clears all marks.

Top module: `predval_store`

## Requirements
- R1: After synchronous reset the table is empty, every mark is clear, and all outputs are zero. A read then returns the register-file value with the error flag low.
- R2: An accepted prediction stores its value under its physical register number and sets the mark of its architectural register. The accept flag (`al0_ok`/`al1_ok`) is high in the cycle after the request.
- R3: Two predictions offered in the same cycle are both accepted when two slots are free. Both values are then read back correctly in one cycle over the two read ports.
- R4: With no free slot the prediction is dropped. Its accept flag stays low and its mark is not set. The table holds exactly 32 entries.
- R5: When both ports request and only one slot is free, port 0 is accepted and port 1 is dropped.
- R6: A read returns the held value when the architectural mark is set and the table holds the physical register. In every other case it returns the register-file input. Results are registered with one cycle of latency.
- R7: A read whose mark is set but whose physical register is not in the table raises `rdN_err` and returns the register-file input.
- R8: The execute port frees the entry tagged with its physical register. It clears the mark only when the supplied current mapping equals that physical register; otherwise the mark stays set. Other entries are untouched.
- R9: A flush frees every entry whose age is numerically greater than the flush age, keeps the rest, and clears all marks. Predictions offered in the flush cycle are dropped.
- R10: Reads see the state from before the current cycle's updates. A value allocated in a cycle is readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| al0_vld | input | 1 | Prediction request, port 0 |
| al0_preg | input | 7 | Destination physical register, port 0 |
| al0_areg | input | 5 | Architectural register, port 0 |
| al0_age | input | 8 | Instruction age, port 0 (larger is younger) |
| al0_val | input | 64 | Predicted value, port 0 |
| al1_vld | input | 1 | Prediction request, port 1 |
| al1_preg | input | 7 | Destination physical register, port 1 |
| al1_areg | input | 5 | Architectural register, port 1 |
| al1_age | input | 8 | Instruction age, port 1 |
| al1_val | input | 64 | Predicted value, port 1 |
| al0_ok | output | 1 | Port 0 request accepted (one cycle later) |
| al1_ok | output | 1 | Port 1 request accepted (one cycle later) |
| rd0_areg | input | 5 | Read 0 architectural register |
| rd0_preg | input | 7 | Read 0 mapped physical register |
| rd0_rf | input | 64 | Read 0 register-file value |
| rd0_data | output | 64 | Read 0 result |
| rd0_err | output | 1 | Read 0 mark set but entry missing |
| rd1_areg | input | 5 | Read 1 architectural register |
| rd1_preg | input | 7 | Read 1 mapped physical register |
| rd1_rf | input | 64 | Read 1 register-file value |
| rd1_data | output | 64 | Read 1 result |
| rd1_err | output | 1 | Read 1 mark set but entry missing |
| ex_vld | input | 1 | Predicted load executed |
| ex_preg | input | 7 | Its physical register |
| ex_areg | input | 5 | Its architectural register |
| ex_map_preg | input | 7 | Current rename mapping of ex_areg |
| fl_vld | input | 1 | Flush |
| fl_age | input | 8 | Flush boundary age |

## Verification
The bench fills the table completely and then offers one more prediction. A design with a capacity that is off by one would accept that extra prediction, or it would corrupt an entry that is still live. It leaves exactly one slot free and requests on both ports. A wrong priority would grant port 1, or it would grant both ports into the same slot. The execute port is driven with a current mapping that does not match. A design that clears the mark anyway would return the register-file value with no error flag; the correct design reports the missing entry. The flush test keeps older entries and counts how many slots come free afterwards. A design that frees by the wrong side of the age boundary would give a count other than sixteen. A design that does not drop predictions in the flush cycle would accept the one offered there.

// File: rtl/predval_pkg.sv
package predval_pkg;
  typedef enum logic {
    RD_FROM_RF  = 1'b0,
    RD_FROM_TBL = 1'b1
  } rd_src_e;
endpackage

// File: rtl/predval_pick.sv
module predval_pick #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  free_i,
  output logic          f0_o,
  output logic [IW-1:0] i0_o,
  output logic          f1_o,
  output logic [IW-1:0] i1_o
);
  // lowest free slot first, second-lowest next
  always_comb begin
    f0_o = 1'b0;
    i0_o = '0;
    f1_o = 1'b0;
    i1_o = '0;
    for (int k = 0; k < N; k++) begin
      if (free_i[k]) begin
        if (!f0_o) begin
          f0_o = 1'b1;
          i0_o = IW'(k);
        end else if (!f1_o) begin
          f1_o = 1'b1;
          i1_o = IW'(k);
        end
      end
    end
  end
endmodule

// File: rtl/predval_cam.sv
module predval_cam #(
  parameter int N      = 32,
  parameter int PREG_W = 7,
  parameter int AGE_W  = 8,
  parameter int DATA_W = 64,
  localparam int IW = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             wr_en,
  input  logic [1:0][IW-1:0]     wr_idx,
  input  logic [1:0][PREG_W-1:0] wr_tag,
  input  logic [1:0][AGE_W-1:0]  wr_age,
  input  logic [1:0][DATA_W-1:0] wr_val,
  input  logic                   rel_en,
  input  logic [PREG_W-1:0]      rel_tag,
  input  logic                   fl_en,
  input  logic [AGE_W-1:0]       fl_age,
  input  logic [1:0][PREG_W-1:0] lk_tag,
  output logic [1:0]             lk_hit,
  output logic [1:0][DATA_W-1:0] lk_val,
  output logic [N-1:0]           free_o
);
  logic [N-1:0]       vld;
  logic [PREG_W-1:0]  tag [N];
  logic [AGE_W-1:0]   age [N];
  logic [DATA_W-1:0]  mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (fl_en && vld[k] && (age[k] > fl_age)) vld[k] <= 1'b0;
        else if (rel_en && vld[k] && (tag[k] == rel_tag)) vld[k] <= 1'b0;
      end
      for (int p = 0; p < 2; p++)
        if (wr_en[p]) vld[wr_idx[p]] <= 1'b1;
    end
  end

  // tag, age and payload carry no reset
  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (wr_en[p]) begin
        tag[wr_idx[p]] <= wr_tag[p];
        age[wr_idx[p]] <= wr_age[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < 2; p++)
      if (wr_en[p]) mem[wr_idx[p]] <= wr_val[p];
  end

  assign free_o = ~vld;

  for (genvar p = 0; p < 2; p++) begin : g_lk
    logic [N-1:0]      hv;
    logic [DATA_W-1:0] v;
    always_comb begin
      v = '0;
      for (int k = 0; k < N; k++) begin
        hv[k] = vld[k] && (tag[k] == lk_tag[p]);
        if (hv[k]) v = v | mem[k];
      end
    end
    assign lk_hit[p] = |hv;
    assign lk_val[p] = v;

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hv));
    // R4
    write_to_free_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en[p] |-> !vld[wr_idx[p]]);
  end
endmodule

// File: rtl/predval_mark.sv
module predval_mark #(
  parameter int AN     = 32,
  parameter int PREG_W = 7,
  localparam int AW = $clog2(AN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          set_en,
  input  logic [1:0][AW-1:0]  set_ar,
  input  logic                clr_en,
  input  logic [AW-1:0]       clr_ar,
  input  logic [PREG_W-1:0]   clr_preg,
  input  logic [PREG_W-1:0]   clr_map,
  input  logic                fl_en,
  output logic [AN-1:0]       bits_o
);
  always_ff @(posedge clk) begin
    if (rst || fl_en) begin
      bits_o <= '0;
    end else begin
      if (clr_en && (clr_map == clr_preg)) bits_o[clr_ar] <= 1'b0;
      for (int p = 0; p < 2; p++)
        if (set_en[p]) bits_o[set_ar[p]] <= 1'b1;
    end
  end

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fl_en) |-> (bits_o == '0));
endmodule

// File: rtl/predval_store.sv
module predval_store #(
  parameter int N      = 32,
  parameter int PREG_W = 7,
  parameter int AREGS  = 32,
  parameter int AGE_W  = 8,
  parameter int DATA_W = 64,
  localparam int IW = $clog2(N),
  localparam int AW = $clog2(AREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              al0_vld,
  input  logic [PREG_W-1:0] al0_preg,
  input  logic [AW-1:0]     al0_areg,
  input  logic [AGE_W-1:0]  al0_age,
  input  logic [DATA_W-1:0] al0_val,
  input  logic              al1_vld,
  input  logic [PREG_W-1:0] al1_preg,
  input  logic [AW-1:0]     al1_areg,
  input  logic [AGE_W-1:0]  al1_age,
  input  logic [DATA_W-1:0] al1_val,
  output logic              al0_ok,
  output logic              al1_ok,
  input  logic [AW-1:0]     rd0_areg,
  input  logic [PREG_W-1:0] rd0_preg,
  input  logic [DATA_W-1:0] rd0_rf,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_err,
  input  logic [AW-1:0]     rd1_areg,
  input  logic [PREG_W-1:0] rd1_preg,
  input  logic [DATA_W-1:0] rd1_rf,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_err,
  input  logic              ex_vld,
  input  logic [PREG_W-1:0] ex_preg,
  input  logic [AW-1:0]     ex_areg,
  input  logic [PREG_W-1:0] ex_map_preg,
  input  logic              fl_vld,
  input  logic [AGE_W-1:0]  fl_age
);
  import predval_pkg::*;

  logic [N-1:0]             free;
  logic                     f0, f1;
  logic [IW-1:0]            i0, i1;
  logic [1:0]               gnt;
  logic [1:0][IW-1:0]       slot;
  logic [1:0]               hit;
  logic [1:0][DATA_W-1:0]   hval;
  logic [AREGS-1:0]         marks;
  logic [1:0][AW-1:0]       rar;
  logic [1:0][DATA_W-1:0]   rrf;
  logic [1:0][DATA_W-1:0]   rdq;
  logic [1:0]               erq;

  predval_pick #(.N(N)) u_pick (
    .free_i(free), .f0_o(f0), .i0_o(i0), .f1_o(f1), .i1_o(i1)
  );

  // port 0 takes the lowest free slot; port 1 the next one
  always_comb begin
    gnt[0]  = al0_vld && !fl_vld && f0;
    gnt[1]  = al1_vld && !fl_vld && (al0_vld ? f1 : f0);
    slot[0] = i0;
    slot[1] = al0_vld ? i1 : i0;
  end

  predval_cam #(.N(N), .PREG_W(PREG_W), .AGE_W(AGE_W), .DATA_W(DATA_W)) u_cam (
    .clk(clk), .rst(rst),
    .wr_en(gnt), .wr_idx(slot),
    .wr_tag({al1_preg, al0_preg}), .wr_age({al1_age, al0_age}),
    .wr_val({al1_val, al0_val}),
    .rel_en(ex_vld), .rel_tag(ex_preg),
    .fl_en(fl_vld), .fl_age(fl_age),
    .lk_tag({rd1_preg, rd0_preg}), .lk_hit(hit), .lk_val(hval),
    .free_o(free)
  );

  predval_mark #(.AN(AREGS), .PREG_W(PREG_W)) u_mark (
    .clk(clk), .rst(rst),
    .set_en(gnt), .set_ar({al1_areg, al0_areg}),
    .clr_en(ex_vld), .clr_ar(ex_areg), .clr_preg(ex_preg), .clr_map(ex_map_preg),
    .fl_en(fl_vld), .bits_o(marks)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      al0_ok <= 1'b0;
      al1_ok <= 1'b0;
    end else begin
      al0_ok <= gnt[0];
      al1_ok <= gnt[1];
    end
  end

  assign rar = {rd1_areg, rd0_areg};
  assign rrf = {rd1_rf, rd0_rf};

  for (genvar p = 0; p < 2; p++) begin : g_rd
    rd_src_e           src;
    logic [DATA_W-1:0] dq;
    logic              eq;
    assign src = (marks[rar[p]] && hit[p]) ? RD_FROM_TBL : RD_FROM_RF;
    always_ff @(posedge clk) begin
      if (rst) begin
        dq <= '0;
        eq <= 1'b0;
      end else begin
        dq <= (src == RD_FROM_TBL) ? hval[p] : rrf[p];
        eq <= marks[rar[p]] && !hit[p];
      end
    end
    assign rdq[p] = dq;
    assign erq[p] = eq;
  end

  assign rd0_data = rdq[0];
  assign rd1_data = rdq[1];
  assign rd0_err  = erq[0];
  assign rd1_err  = erq[1];

  // R5
  port0_first_chk: assert property (@(posedge clk) disable iff (rst)
    (al1_ok && $past(al0_vld)) |-> al0_ok);
  // R9
  no_grant_in_flush_chk: assert property (@(posedge clk) disable iff (rst)
    al0_ok |-> $past(al0_vld && !fl_vld));
  // R7
  err_uses_rf0_chk: assert property (@(posedge clk) disable iff (rst)
    rd0_err |-> (rd0_data == $past(rd0_rf)));
  // R7
  err_uses_rf1_chk: assert property (@(posedge clk) disable iff (rst)
    rd1_err |-> (rd1_data == $past(rd1_rf)));
endmodule

// File: tb/test_predval_store.sv
module test_predval_store;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic al0_vld = 0, al1_vld = 0, ex_vld = 0, fl_vld = 0;
  logic [6:0] al0_preg = 0, al1_preg = 0, rd0_preg = 0, rd1_preg = 0, ex_preg = 0, ex_map_preg = 0;
  logic [4:0] al0_areg = 0, al1_areg = 0, rd0_areg = 0, rd1_areg = 0, ex_areg = 0;
  logic [7:0] al0_age = 0, al1_age = 0, fl_age = 0;
  logic [63:0] al0_val = 0, al1_val = 0, rd0_rf = 0, rd1_rf = 0;
  logic al0_ok, al1_ok, rd0_err, rd1_err;
  logic [63:0] rd0_data, rd1_data;

  int checks = 0, fails = 0;

  predval_store i_predval_store (
    .clk(clk), .rst(rst),
    .al0_vld(al0_vld), .al0_preg(al0_preg), .al0_areg(al0_areg), .al0_age(al0_age), .al0_val(al0_val),
    .al1_vld(al1_vld), .al1_preg(al1_preg), .al1_areg(al1_areg), .al1_age(al1_age), .al1_val(al1_val),
    .al0_ok(al0_ok), .al1_ok(al1_ok),
    .rd0_areg(rd0_areg), .rd0_preg(rd0_preg), .rd0_rf(rd0_rf), .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_areg(rd1_areg), .rd1_preg(rd1_preg), .rd1_rf(rd1_rf), .rd1_data(rd1_data), .rd1_err(rd1_err),
    .ex_vld(ex_vld), .ex_preg(ex_preg), .ex_areg(ex_areg), .ex_map_preg(ex_map_preg),
    .fl_vld(fl_vld), .fl_age(fl_age)
  );

  task automatic chk(input string rq, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  // inputs set after a falling edge; results read at the next falling edge
  task automatic tick();
    @(negedge clk);
    al0_vld = 0; al1_vld = 0; ex_vld = 0; fl_vld = 0;
  endtask

  task automatic set_al(input int port, input int preg, input int areg, input int age, input logic [63:0] v);
    if (port == 0) begin
      al0_vld = 1; al0_preg = 7'(preg); al0_areg = 5'(areg); al0_age = 8'(age); al0_val = v;
    end else begin
      al1_vld = 1; al1_preg = 7'(preg); al1_areg = 5'(areg); al1_age = 8'(age); al1_val = v;
    end
  endtask

  task automatic set_rd(input int port, input int areg, input int preg, input logic [63:0] rf);
    if (port == 0) begin rd0_areg = 5'(areg); rd0_preg = 7'(preg); rd0_rf = rf; end
    else begin rd1_areg = 5'(areg); rd1_preg = 7'(preg); rd1_rf = rf; end
  endtask

  task automatic t_reset();
    chk("R1 ok0", {63'd0, al0_ok}, 64'd0);
    chk("R1 ok1", {63'd0, al1_ok}, 64'd0);
    chk("R1 data0", rd0_data, 64'd0);
    chk("R1 err0", {63'd0, rd0_err}, 64'd0);
    set_rd(0, 3, 10, 64'h55);
    tick();
    chk("R1 rf read", rd0_data, 64'h55);
    chk("R1 no err", {63'd0, rd0_err}, 64'd0);
  endtask

  task automatic t_single();
    set_al(0, 10, 3, 5, 64'hA0);
    set_rd(0, 3, 10, 64'h11);
    tick();
    chk("R2 ok0", {63'd0, al0_ok}, 64'd1);
    chk("R10 old state", rd0_data, 64'h11);
    set_rd(0, 3, 10, 64'h11);
    set_rd(1, 4, 11, 64'hB);
    tick();
    chk("R6 table value", rd0_data, 64'hA0);
    chk("R6 rf value", rd1_data, 64'hB);
    chk("R6 no err", {63'd0, rd1_err}, 64'd0);
  endtask

  task automatic t_dual();
    set_al(0, 20, 5, 6, 64'hC0);
    set_al(1, 21, 6, 7, 64'hC1);
    tick();
    chk("R3 ok0", {63'd0, al0_ok}, 64'd1);
    chk("R3 ok1", {63'd0, al1_ok}, 64'd1);
    set_rd(0, 5, 20, 64'h0);
    set_rd(1, 6, 21, 64'h0);
    tick();
    chk("R3 read0", rd0_data, 64'hC0);
    chk("R3 read1", rd1_data, 64'hC1);
  endtask

  task automatic t_err();
    set_rd(0, 3, 99, 64'hEE);
    tick();
    chk("R7 err", {63'd0, rd0_err}, 64'd1);
    chk("R7 data", rd0_data, 64'hEE);
  endtask

  task automatic t_exec();
    ex_vld = 1; ex_preg = 10; ex_areg = 3; ex_map_preg = 10;
    tick();
    set_rd(0, 3, 10, 64'h12);
    tick();
    chk("R8 cleared data", rd0_data, 64'h12);
    chk("R8 cleared err", {63'd0, rd0_err}, 64'd0);
    ex_vld = 1; ex_preg = 20; ex_areg = 5; ex_map_preg = 40;
    tick();
    set_rd(0, 5, 20, 64'h13);
    set_rd(1, 6, 21, 64'h0);
    tick();
    chk("R8 kept mark err", {63'd0, rd0_err}, 64'd1);
    chk("R8 kept mark data", rd0_data, 64'h13);
    chk("R8 other entry", rd1_data, 64'hC1);
  endtask

  task automatic t_full();
    int acc = 0;
    fl_vld = 1; fl_age = 0;
    tick();
    for (int i = 0; i < 16; i++) begin
      set_al(0, 64 + 2 * i, i, (i < 8) ? 10 : 30, 64'(1000 + i));
      set_al(1, 65 + 2 * i, i, (i < 8) ? 10 : 30, 64'(2000 + i));
      tick();
      acc += int'(al0_ok) + int'(al1_ok);
    end
    chk("R4 capacity", 64'(acc), 64'd32);
    set_al(0, 96, 31, 10, 64'h96);
    tick();
    chk("R4 dropped", {63'd0, al0_ok}, 64'd0);
    set_rd(0, 31, 96, 64'h7);
    tick();
    chk("R4 mark not set data", rd0_data, 64'h7);
    chk("R4 mark not set err", {63'd0, rd0_err}, 64'd0);
    ex_vld = 1; ex_preg = 64; ex_areg = 0; ex_map_preg = 64;
    tick();
    set_al(0, 97, 20, 10, 64'h97);
    set_al(1, 98, 21, 10, 64'h98);
    tick();
    chk("R5 port0 wins", {63'd0, al0_ok}, 64'd1);
    chk("R5 port1 dropped", {63'd0, al1_ok}, 64'd0);
    set_rd(0, 20, 97, 64'h0);
    set_rd(1, 21, 98, 64'h21);
    tick();
    chk("R5 port0 value", rd0_data, 64'h97);
    chk("R5 port1 no mark", rd1_data, 64'h21);
    chk("R5 port1 no err", {63'd0, rd1_err}, 64'd0);
  endtask

  task automatic t_flush();
    int acc = 0;
    fl_vld = 1; fl_age = 10;
    set_al(0, 99, 22, 1, 64'h99);
    tick();
    chk("R9 alloc in flush dropped", {63'd0, al0_ok}, 64'd0);
    set_rd(0, 20, 97, 64'h5);
    tick();
    chk("R9 marks cleared data", rd0_data, 64'h5);
    chk("R9 marks cleared err", {63'd0, rd0_err}, 64'd0);
    for (int i = 0; i < 20; i++) begin
      set_al(0, 100 + i, 23, 1, 64'(i));
      tick();
      acc += int'(al0_ok);
    end
    chk("R9 younger freed older kept", 64'(acc), 64'd16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_single();
    t_dual();
    t_err();
    t_exec();
    t_full();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule